// File: doc/BRIEF.md
# Programmable Modem Clock Generator with Phase Trimming

The block turns one master clock into the timing strobes for both directions of a modem. Each direction has a chain of down-counters. A sample counter divides the master clock and drives the converter sampling strobe. A baud counter counts sample strobes. A data counter restarts on every baud strobe. Each strobe is a single-cycle clock enable, not a gated clock. The converter words these strobes qualify are two's complement. All three strobes of a direction fall together on every baud boundary, so a phase correction moves them as a group. A correction never changes the programmed ratios. Instead, the sample period that opens the next baud period is made one master cycle shorter (advance) or one longer (retard).

The transmit side corrects itself. An external reference pin passes through a two-flop synchronizer. Each detected rising edge is placed inside the current baud period, and the loop then requests the correction that pulls the baud strobe toward the edge. The receive side is open loop. A host write loads a signed step count, and the shifter spends that count at one step per receive baud period. A status pin stays high while steps remain.

State machines: the transmit loop has TL_TRACK, TL_ADV and TL_RET. TL_TRACK goes to TL_RET or TL_ADV on a classified edge. Either pending state returns to TL_TRACK when the chain takes the step. The receive shifter has RS_IDLE, RS_ADV and RS_RET. A host write of a positive, negative or zero count moves it to RS_ADV, RS_RET or RS_IDLE from any state. When the last step is taken, it goes from RS_ADV or RS_RET back to RS_IDLE.

Top module: `modem_clkgen`

## Requirements
- R1: While `rst` is high every strobe output is low and `rx_adj_pending` is low. In the first cycle after release, all six strobes pulse together.
- R2: Write addresses: bit 2 picks the direction (0 transmit, 1 receive). Bits 1:0 pick sample divisor (0), baud ratio (1) or data divisor (2). Address 7 is the receive step count. Address 3 is unused, and a write there changes no output. A write to one direction leaves the other direction's periods unchanged.
- R3: Without corrections, a direction's sample strobe repeats every S master cycles, where S is the programmed sample divisor.
- R4: Without corrections, the baud strobe repeats every S*K master cycles, where K is the baud ratio.
- R5: The data strobe restarts with each baud strobe and then repeats every D master cycles (D is the data divisor) until the next baud strobe.
- R6: A sample divisor below 3 acts as 3. A baud ratio or data divisor of 0 acts as 1.
- R7: Every baud strobe coincides with a sample strobe and a data strobe of its direction, including after a correction.
- R8: A transmit reference edge detected in the first half of a baud period (at most S*K/2 cycles after the last baud strobe) makes the following baud period S*K+1 cycles long.
- R9: A transmit reference edge detected later than the midpoint makes the following baud period S*K-1 cycles long.
- R10: A reference edge detected in the same cycle as a transmit baud strobe causes no correction. Edges detected while a correction is pending are ignored. At most one correction is applied per baud period.
- R11: Writing a positive count N to address 7 (low 8 bits, two's complement) raises `rx_adj_pending` in the next cycle. The next N receive baud periods are then each one cycle short, and afterwards the pin falls.
- R12: A negative count -N makes the next N receive baud periods each one cycle long.
- R13: A new count replaces any steps still pending. A count of zero drops `rx_adj_pending` in the next cycle and leaves the receive periods nominal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register write address |
| cfg_wdata | input | DIV_W | Register write data |
| tx_ref | input | 1 | Asynchronous transmit reference, rising edge tracked |
| tx_samp_en | output | 1 | Transmit converter sample strobe |
| tx_baud_en | output | 1 | Transmit baud strobe |
| tx_data_en | output | 1 | Transmit data-rate strobe |
| rx_samp_en | output | 1 | Receive converter sample strobe |
| rx_baud_en | output | 1 | Receive baud strobe |
| rx_data_en | output | 1 | Receive data-rate strobe |
| rx_adj_pending | output | 1 | Receive phase steps remain |

## Verification
A wrong counter or reload value shows up within one baud period. It appears as a sample, baud or data interval that differs from the programmed value, or as a baud strobe without its sample and data strobes. A wrong decision in the transmit loop or the receive shifter appears only on the baud periods that follow the event. So the bench measures each interval after a known reference edge or host write, and it expects exactly one or exactly N periods to be off by one cycle before the period returns to nominal. A step count that was dropped or duplicated shows at the status pin after the expected number of baud strobes.

// File: rtl/mclk_pkg.sv
package mclk_pkg;

    // one-cycle trim request handed to a divider chain
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_ADV  = 2'd1,
        STEP_RET  = 2'd2
    } step_e;

    // register select within a direction (address bits 1:0)
    localparam logic [1:0] REG_SAMP  = 2'd0;
    localparam logic [1:0] REG_RATIO = 2'd1;
    localparam logic [1:0] REG_DATA  = 2'd2;
    localparam logic [1:0] REG_PHASE = 2'd3;

    // smallest sample divisor that keeps an advanced period at two cycles
    localparam int MIN_SAMP = 3;

endpackage

// File: rtl/mclk_chain.sv
module mclk_chain
    import mclk_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] samp_div,
    input  logic [DIV_W-1:0] ratio,
    input  logic [DIV_W-1:0] data_div,
    input  step_e            step,
    output logic             samp_en,
    output logic             baud_en,
    output logic             data_en,
    output logic             step_done
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
    localparam logic [DIV_W-1:0] TWO = DIV_W'(2);

    logic [DIV_W-1:0] s_cnt, b_cnt, d_cnt;
    logic [DIV_W-1:0] s_eff, k_eff, d_eff, s_load;

    always_comb begin
        s_eff = (samp_div < DIV_W'(MIN_SAMP)) ? DIV_W'(MIN_SAMP) : samp_div;
        k_eff = (ratio == '0) ? ONE : ratio;
        d_eff = (data_div == '0) ? ONE : data_div;
    end

    assign samp_en   = !rst && (s_cnt == '0);
    assign baud_en   = samp_en && (b_cnt == '0);
    assign data_en   = !rst && ((d_cnt == '0) || baud_en);
    assign step_done = baud_en && (step != STEP_NONE);

    // the sample period opening a baud period carries the trim
    always_comb begin
        s_load = s_eff - ONE;
        if (baud_en) begin
            unique case (step)
                STEP_ADV: s_load = s_eff - TWO;
                STEP_RET: s_load = s_eff;
                default:  s_load = s_eff - ONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_cnt <= '0;
            b_cnt <= '0;
            d_cnt <= '0;
        end else begin
            s_cnt <= samp_en ? s_load : s_cnt - ONE;
            if (samp_en) begin
                b_cnt <= (b_cnt == '0) ? k_eff - ONE : b_cnt - ONE;
            end
            d_cnt <= data_en ? d_eff - ONE : d_cnt - ONE;
        end
    end

endmodule

// File: rtl/mclk_txloop.sv
module mclk_txloop
    import mclk_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic             baud_en,
    input  logic             step_done,
    input  logic [DIV_W-1:0] samp_div,
    input  logic [DIV_W-1:0] ratio,
    output step_e            step
);

    localparam int EW = 2 * DIV_W;

    typedef enum logic [1:0] {
        TL_TRACK = 2'd0,
        TL_ADV   = 2'd1,
        TL_RET   = 2'd2
    } tl_state_e;

    tl_state_e        st_q, st_d;
    logic [2:0]       sync_q;
    logic             edge_seen;
    logic [EW-1:0]    elapsed_q, half;
    logic [DIV_W-1:0] s_eff, k_eff;

    always_comb begin
        s_eff = (samp_div < DIV_W'(MIN_SAMP)) ? DIV_W'(MIN_SAMP) : samp_div;
        k_eff = (ratio == '0) ? DIV_W'(1) : ratio;
        half  = (EW'(s_eff) * EW'(k_eff)) >> 1;
    end

    assign edge_seen = sync_q[1] & ~sync_q[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q    <= '0;
            elapsed_q <= '0;
        end else begin
            sync_q <= {sync_q[1:0], ref_in};
            if (baud_en) begin
                elapsed_q <= EW'(1);
            end else if (!(&elapsed_q)) begin
                elapsed_q <= elapsed_q + EW'(1);
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= TL_TRACK;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TL_TRACK: begin
                if (edge_seen && !baud_en) begin
                    st_d = (elapsed_q <= half) ? TL_RET : TL_ADV;
                end
            end
            TL_ADV, TL_RET: begin
                if (step_done) begin
                    st_d = TL_TRACK;
                end
            end
            default: st_d = TL_TRACK;
        endcase
    end

    // outputs
    always_comb begin
        unique case (st_q)
            TL_ADV:  step = STEP_ADV;
            TL_RET:  step = STEP_RET;
            default: step = STEP_NONE;
        endcase
    end

endmodule

// File: rtl/mclk_rxshift.sv
module mclk_rxshift
    import mclk_pkg::*;
#(
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [STEP_W-1:0] load_val,
    input  logic              step_done,
    output step_e             step,
    output logic              pending
);

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_ADV  = 2'd1,
        RS_RET  = 2'd2
    } rs_state_e;

    rs_state_e         st_q, st_d;
    logic [STEP_W-1:0] left_q, left_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= RS_IDLE;
            left_q <= '0;
        end else begin
            st_q   <= st_d;
            left_q <= left_d;
        end
    end

    // next state: a host load overrides any step in the same cycle
    always_comb begin
        st_d   = st_q;
        left_d = left_q;
        if (load) begin
            if (load_val == '0) begin
                st_d   = RS_IDLE;
                left_d = '0;
            end else if (load_val[STEP_W-1]) begin
                st_d   = RS_RET;
                left_d = '0 - load_val;
            end else begin
                st_d   = RS_ADV;
                left_d = load_val;
            end
        end else begin
            unique case (st_q)
                RS_ADV, RS_RET: begin
                    if (step_done) begin
                        if (left_q == STEP_W'(1)) begin
                            st_d   = RS_IDLE;
                            left_d = '0;
                        end else begin
                            left_d = left_q - STEP_W'(1);
                        end
                    end
                end
                default: st_d = RS_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            RS_ADV:  step = STEP_ADV;
            RS_RET:  step = STEP_RET;
            default: step = STEP_NONE;
        endcase
        pending = (st_q != RS_IDLE);
    end

endmodule

// File: rtl/modem_clkgen.sv
module modem_clkgen
    import mclk_pkg::*;
#(
    parameter int DIV_W     = 12,
    parameter int STEP_W    = 8,
    parameter int SAMP_RST  = 8,
    parameter int RATIO_RST = 4,
    parameter int DATA_RST  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [DIV_W-1:0] cfg_wdata,
    input  logic             tx_ref,
    output logic             tx_samp_en,
    output logic             tx_baud_en,
    output logic             tx_data_en,
    output logic             rx_samp_en,
    output logic             rx_baud_en,
    output logic             rx_data_en,
    output logic             rx_adj_pending
);

    localparam int NDIR   = 2;
    localparam int DIR_TX = 0;
    localparam int DIR_RX = 1;

    logic [DIV_W-1:0] samp_q  [NDIR];
    logic [DIV_W-1:0] ratio_q [NDIR];
    logic [DIV_W-1:0] data_q  [NDIR];
    logic             samp_w  [NDIR];
    logic             baud_w  [NDIR];
    logic             data_w  [NDIR];
    logic             done_w  [NDIR];
    step_e            step_w  [NDIR];

    logic phase_load;
    assign phase_load = cfg_we && (cfg_addr == {1'b1, REG_PHASE});

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        logic hit;
        assign hit = cfg_we && (cfg_addr[2] == 1'(d));

        always_ff @(posedge clk) begin
            if (rst) begin
                samp_q[d]  <= DIV_W'(SAMP_RST);
                ratio_q[d] <= DIV_W'(RATIO_RST);
                data_q[d]  <= DIV_W'(DATA_RST);
            end else if (hit) begin
                unique case (cfg_addr[1:0])
                    REG_SAMP:  samp_q[d]  <= cfg_wdata;
                    REG_RATIO: ratio_q[d] <= cfg_wdata;
                    REG_DATA:  data_q[d]  <= cfg_wdata;
                    default:   ;
                endcase
            end
        end

        mclk_chain #(.DIV_W(DIV_W)) u_chain (
            .clk      (clk),
            .rst      (rst),
            .samp_div (samp_q[d]),
            .ratio    (ratio_q[d]),
            .data_div (data_q[d]),
            .step     (step_w[d]),
            .samp_en  (samp_w[d]),
            .baud_en  (baud_w[d]),
            .data_en  (data_w[d]),
            .step_done(done_w[d])
        );
    end

    mclk_txloop #(.DIV_W(DIV_W)) u_txloop (
        .clk      (clk),
        .rst      (rst),
        .ref_in   (tx_ref),
        .baud_en  (baud_w[DIR_TX]),
        .step_done(done_w[DIR_TX]),
        .samp_div (samp_q[DIR_TX]),
        .ratio    (ratio_q[DIR_TX]),
        .step     (step_w[DIR_TX])
    );

    mclk_rxshift #(.STEP_W(STEP_W)) u_rxshift (
        .clk      (clk),
        .rst      (rst),
        .load     (phase_load),
        .load_val (cfg_wdata[STEP_W-1:0]),
        .step_done(done_w[DIR_RX]),
        .step     (step_w[DIR_RX]),
        .pending  (rx_adj_pending)
    );

    assign tx_samp_en = samp_w[DIR_TX];
    assign tx_baud_en = baud_w[DIR_TX];
    assign tx_data_en = data_w[DIR_TX];
    assign rx_samp_en = samp_w[DIR_RX];
    assign rx_baud_en = baud_w[DIR_RX];
    assign rx_data_en = data_w[DIR_RX];

endmodule

// File: rtl/mclk_checker.sv
module mclk_checker #(
    parameter int STEP_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [2:0]        cfg_addr,
    input logic [STEP_W-1:0] step_val,
    input logic              tx_samp_en,
    input logic              tx_baud_en,
    input logic              tx_data_en,
    input logic              rx_samp_en,
    input logic              rx_baud_en,
    input logic              rx_data_en,
    input logic              rx_adj_pending
);

    logic phase_wr;
    assign phase_wr = cfg_we && (cfg_addr == 3'd7);

    // R1
    always @(posedge clk) begin
        if (rst) begin
            quiet_in_reset_chk: assert (!tx_samp_en && !tx_baud_en && !tx_data_en &&
                                        !rx_samp_en && !rx_baud_en && !rx_data_en);
        end
    end

    // R7
    tx_baud_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        tx_baud_en |-> (tx_samp_en && tx_data_en));

    // R7
    rx_baud_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        rx_baud_en |-> (rx_samp_en && rx_data_en));

    // R3
    tx_samp_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tx_samp_en |=> !tx_samp_en);

    // R3
    rx_samp_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        rx_samp_en |=> !rx_samp_en);

    // R11
    rx_pending_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_wr && (step_val != '0)) |=> rx_adj_pending);

    // R13
    rx_pending_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_wr && (step_val == '0)) |=> !rx_adj_pending);

    // R11
    rx_pending_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_adj_pending) |-> $past(rx_baud_en || cfg_we));

endmodule

bind modem_clkgen mclk_checker #(.STEP_W(STEP_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_we        (cfg_we),
    .cfg_addr      (cfg_addr),
    .step_val      (cfg_wdata[STEP_W-1:0]),
    .tx_samp_en    (tx_samp_en),
    .tx_baud_en    (tx_baud_en),
    .tx_data_en    (tx_data_en),
    .rx_samp_en    (rx_samp_en),
    .rx_baud_en    (rx_baud_en),
    .rx_data_en    (rx_data_en),
    .rx_adj_pending(rx_adj_pending)
);

// File: tb/modem_clkgen_test.sv
module modem_clkgen_test;

    localparam int DIV_W = 12;
    localparam int TX = 0;
    localparam int RX = 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [2:0]       cfg_addr = 3'd0;
    logic [DIV_W-1:0] cfg_wdata = '0;
    logic             tx_ref = 1'b0;
    logic tx_samp_en, tx_baud_en, tx_data_en;
    logic rx_samp_en, rx_baud_en, rx_data_en, rx_adj_pending;

    modem_clkgen #(.DIV_W(DIV_W)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tx_ref(tx_ref),
        .tx_samp_en(tx_samp_en), .tx_baud_en(tx_baud_en), .tx_data_en(tx_data_en),
        .rx_samp_en(rx_samp_en), .rx_baud_en(rx_baud_en), .rx_data_en(rx_data_en),
        .rx_adj_pending(rx_adj_pending)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int s_last[2] = '{0, 0};
    int s_int[2] = '{0, 0};
    int b_last[2] = '{0, 0};
    int b_int[2] = '{0, 0};
    int b_cnt[2] = '{0, 0};
    int d_last[2] = '{0, 0};
    int d_int[2] = '{0, 0};
    int coin_err[2] = '{0, 0};

    function automatic int eff_samp(int s);
        return (s < 3) ? 3 : s;
    endfunction

    function automatic int exp_period(int s, int k);
        return eff_samp(s) * ((k < 1) ? 1 : k);
    endfunction

    task automatic mon(int d, logic s, logic b, logic t);
        if (s) begin s_int[d] = cyc - s_last[d]; s_last[d] = cyc; end
        if (b) begin
            b_int[d] = cyc - b_last[d];
            b_last[d] = cyc;
            b_cnt[d]++;
            if (!(s && t)) coin_err[d]++;
        end
        if (t && !b) d_int[d] = cyc - d_last[d];
        if (t) d_last[d] = cyc;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            mon(TX, tx_samp_en, tx_baud_en, tx_data_en);
            mon(RX, rx_samp_en, rx_baud_en, rx_data_en);
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc_wait(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic write(int addr, int data);
        @(posedge clk); #2;
        cfg_we = 1'b1;
        cfg_addr = 3'(addr);
        cfg_wdata = DIV_W'(data);
        @(posedge clk); #2;
        cfg_we = 1'b0;
    endtask

    task automatic wait_ticks(int d, int n);
        int target = b_cnt[d] + n;
        wait (b_cnt[d] >= target);
    endtask

    task automatic set_dir(int d, int s, int k, int dd);
        write(d * 4 + 0, s);
        write(d * 4 + 1, k);
        write(d * 4 + 2, dd);
        wait_ticks(d, 1);
        d_int[d] = 0;
        wait_ticks(d, 2);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd17));

        // R1 quiet during reset
        repeat (3) begin
            @(negedge clk);
            check("R1 strobes in reset", int'({tx_samp_en, tx_baud_en, tx_data_en,
                  rx_samp_en, rx_baud_en, rx_data_en}), 0);
            check("R1 pending in reset", int'(rx_adj_pending), 0);
        end
        @(posedge clk); #2;
        rst = 1'b0;
        @(negedge clk);
        check("R1 first strobes", int'({tx_samp_en, tx_baud_en, tx_data_en,
              rx_samp_en, rx_baud_en, rx_data_en}), 6'b111111);

        // defaults S=8 K=4 D=8
        wait_ticks(TX, 3);
        check("R3 tx sample", s_int[TX], 8);
        check("R4 tx baud", b_int[TX], 32);
        check("R5 tx data", d_int[TX], 8);
        check("R3 rx sample", s_int[RX], 8);
        check("R4 rx baud", b_int[RX], 32);

        // R2 unused address and direction isolation
        write(3, 5);
        wait_ticks(TX, 2);
        check("R2 addr3 tx baud", b_int[TX], 32);
        check("R2 addr3 pending", int'(rx_adj_pending), 0);
        set_dir(RX, 5, 2, 5);
        check("R2 rx reprogrammed", b_int[RX], 10);
        wait_ticks(TX, 2);
        check("R2 tx untouched", b_int[TX], 32);

        // R6 clamps
        set_dir(RX, 1, 0, 0);
        check("R6 sample clamp", s_int[RX], 3);
        check("R6 ratio clamp", b_int[RX], 3);
        check("R6 data clamp", d_int[RX], 1);

        // random configurations, R3 R4 R5
        for (int i = 0; i < 8; i++) begin
            int d = i % 2;
            int s = 3 + int'($urandom % 8);
            int k = 1 + int'($urandom % 5);
            int p = exp_period(s, k);
            int dd = 1 + int'($urandom % (p + 2));
            set_dir(d, s, k, dd);
            check("R3 random sample", s_int[d], eff_samp(s));
            check("R4 random baud", b_int[d], p);
            check("R5 random data", d_int[d], (dd < p) ? dd : 0);
        end

        set_dir(TX, 8, 4, 8);
        set_dir(RX, 8, 4, 8);

        // R8 early edge -> retard
        wait_ticks(TX, 1);
        cyc_wait(3); tx_ref = 1'b1;
        cyc_wait(4); tx_ref = 1'b0;
        wait_ticks(TX, 2);
        check("R8 retarded period", b_int[TX], 33);
        wait_ticks(TX, 1);
        check("R8 back to nominal", b_int[TX], 32);

        // R9 late edge -> advance
        wait_ticks(TX, 1);
        cyc_wait(26); tx_ref = 1'b1;
        cyc_wait(2); tx_ref = 1'b0;
        wait_ticks(TX, 2);
        check("R9 advanced period", b_int[TX], 31);

        // R10 edge on the tick
        wait_ticks(TX, 1);
        cyc_wait(30); tx_ref = 1'b1;
        cyc_wait(3); tx_ref = 1'b0;
        wait_ticks(TX, 1);
        check("R10 coincident edge", b_int[TX], 32);
        wait_ticks(TX, 1);
        check("R10 coincident edge later", b_int[TX], 32);

        // R10 second edge while pending is ignored
        wait_ticks(TX, 1);
        cyc_wait(3); tx_ref = 1'b1;
        cyc_wait(4); tx_ref = 1'b0;
        cyc_wait(13); tx_ref = 1'b1;
        cyc_wait(4); tx_ref = 1'b0;
        wait_ticks(TX, 2);
        check("R10 one step only", b_int[TX], 33);
        wait_ticks(TX, 1);
        check("R10 second edge ignored", b_int[TX], 32);

        // R11 positive steps
        wait_ticks(RX, 1);
        write(7, 3);
        @(negedge clk);
        check("R11 pending raised", int'(rx_adj_pending), 1);
        wait_ticks(RX, 1);
        for (int i = 0; i < 3; i++) begin
            wait_ticks(RX, 1);
            check("R11 advanced period", b_int[RX], 31);
        end
        check("R11 pending dropped", int'(rx_adj_pending), 0);
        wait_ticks(RX, 1);
        check("R11 nominal after", b_int[RX], 32);

        // R12 negative steps
        wait_ticks(RX, 1);
        write(7, 12'h0FE);
        wait_ticks(RX, 1);
        wait_ticks(RX, 1);
        check("R12 retarded period", b_int[RX], 33);
        wait_ticks(RX, 1);
        check("R12 retarded period", b_int[RX], 33);
        wait_ticks(RX, 1);
        check("R12 nominal after", b_int[RX], 32);
        check("R12 pending dropped", int'(rx_adj_pending), 0);

        // R13 zero cancels
        wait_ticks(RX, 1);
        write(7, 4);
        wait_ticks(RX, 1);
        write(7, 0);
        @(negedge clk);
        check("R13 zero clears pending", int'(rx_adj_pending), 0);
        wait_ticks(RX, 1);
        check("R13 step before cancel", b_int[RX], 31);
        wait_ticks(RX, 1);
        check("R13 nominal after cancel", b_int[RX], 32);

        // R13 replacement
        wait_ticks(RX, 1);
        write(7, 4);
        write(7, 12'h0FF);
        wait_ticks(RX, 2);
        check("R13 replaced count", b_int[RX], 33);
        wait_ticks(RX, 1);
        check("R13 replaced done", b_int[RX], 32);
        check("R13 pending after replace", int'(rx_adj_pending), 0);

        // R7 strobe alignment over the whole run
        check("R7 tx alignment", coin_err[TX], 0);
        check("R7 rx alignment", coin_err[RX], 0);

        summary();
    end

endmodule